// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall-clock time as an unsigned 32-bit count of seconds and compares it against a programmable alarm value. A one-second strobe from an external prescaler advances the count. Software reaches the block through a small byte-wide register port: an address, write data with a write enable, and a combinational read-data output.

Setting the time is a staged operation. Software writes the three upper bytes of the new value into holding registers, then writes the lowest byte. That last write moves all four bytes into the running counter in a single clock edge, so the counter never holds a value that mixes old and new bytes. Reading the time goes through a separate window that always shows the live counter. A reader that sees the low byte shrink on a second read knows that a carry rippled through during a multi-byte read, and reads again.

When counting and the alarm are both enabled and a strobe arrives while the count equals the alarm value, a sticky pending flag is set. This flag drives a level interrupt output that goes from low to high. The flag stays set until software writes a one to the clear bit in a second control register.

Top module: `secAlarmRtc`

## Requirements
- R1: After reset the counter, the staging bytes, the alarm value, both enable bits and the pending flag are all zero, and `alarmIrq` is low.
- R2: The control register is at offset 0. Bit 7 enables counting and bit 1 enables the alarm. Every other bit of it reads as 0, whatever was written.
- R3: While bit 7 is set, every cycle with `tick` high adds one to the counter, and the counter wraps from 0xFFFFFFFF to 0. While bit 7 is clear, the counter holds its value.
- R4: Writes to offsets 3, 4 and 5 (time bytes 1, 2 and 3) only fill a staging buffer. They leave the live counter unchanged.
- R5: A write to offset 2 loads the counter with {staged byte 3, staged byte 2, staged byte 1, written byte} at the next edge. This load takes precedence over a tick in the same cycle.
- R6: Offsets 6 to 9 read the live counter, least significant byte at offset 6. Writes to these offsets are ignored.
- R7: Offsets 10 to 13 hold the alarm value in little-endian byte order, least significant byte at offset 10. It can be written and read back.
- R8: When counting and the alarm are both enabled and `tick` is high in a cycle where the counter equals the alarm value, the pending flag is set at that edge. `alarmIrq` then rises and stays high through later ticks.
- R9: Offset 1 bit 0 reads back the pending flag. Writing 1 to it clears the flag, and writing 0 has no effect. If a clear and an alarm match land in the same cycle, the flag ends up set.
- R10: No alarm fires while the alarm enable is clear, and none fires while counting is disabled.
- R11: The time-write offsets 2 to 5 and the unmapped offsets 14 and 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second strobe, one cycle wide |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write data byte |
| wrEn | input | 1 | Write strobe for the addressed register |
| rdData | output | 8 | Read data for the addressed register, combinational |
| alarmIrq | output | 1 | Level alarm interrupt, high while the alarm is pending |

## Verification
The bench builds the block with its default parameters: four byte lanes of eight bits and a 4-bit address. With these values every register offset, including the two unmapped ones, can be reached from the port. The counter wrap is exercised by loading 0xFFFFFFFE through the staged write path and then issuing two ticks, rather than by counting up from zero. The alarm match is reached the same way: the counter is loaded just below a carry out of the low byte, so a single match also crosses a byte boundary.

// File: rtl/secRtcPkg.sv
package secRtcPkg;
  // byte lane index width; covers up to 16 lanes
  localparam int IDX_W = 4;

  // control register bit positions (software decodes these)
  localparam int CNT_EN_BIT = 7;
  localparam int ALM_EN_BIT = 1;
  // control-2 register
  localparam int PEND_BIT   = 0;

  // fixed offsets at the front of the map
  localparam int CTRL_OFS  = 0;
  localparam int CTRL2_OFS = 1;
  localparam int WR_OFS    = 2;

  typedef struct packed {
    logic             loadLive;  // low time byte written: commit staged value
    logic             stageWr;   // upper time byte written into staging
    logic             almWr;     // alarm byte written
    logic             clrPend;   // write-one-to-clear of pending flag
    logic [IDX_W-1:0] byteIdx;   // lane for stageWr / almWr
  } rtcStrobes_t;
endpackage

// File: rtl/secRtcCtrl.sv
module secRtcCtrl
  import secRtcPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BYTES  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wrEn,
  input  logic                     wrCntBit,
  input  logic                     wrAlmBit,
  input  logic                     wrPendBit,
  input  logic [BYTES*DATA_W-1:0]  liveCount,
  input  logic [BYTES*DATA_W-1:0]  alarmVal,
  input  logic                     pending,
  output rtcStrobes_t              strb,
  output logic                     countEn,
  output logic                     alarmEn,
  output logic [DATA_W-1:0]        rdData
);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] CTRL2_A = ADDR_W'(CTRL2_OFS);
  localparam logic [ADDR_W-1:0] WR_A    = ADDR_W'(WR_OFS);
  localparam logic [ADDR_W-1:0] RD_A    = ADDR_W'(WR_OFS + BYTES);
  localparam logic [ADDR_W-1:0] AL_A    = ADDR_W'(WR_OFS + 2 * BYTES);
  localparam logic [ADDR_W-1:0] END_A   = ADDR_W'(WR_OFS + 3 * BYTES);

  // write decode into strobes
  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (addr == WR_A) begin
        strb.loadLive = 1'b1;
      end else if (addr > WR_A && addr < RD_A) begin
        strb.stageWr = 1'b1;
        strb.byteIdx = IDX_W'(addr - WR_A);
      end else if (addr >= AL_A && addr < END_A) begin
        strb.almWr   = 1'b1;
        strb.byteIdx = IDX_W'(addr - AL_A);
      end
      if (addr == CTRL2_A && wrPendBit) strb.clrPend = 1'b1;
    end
  end

  // control register: only the two defined bits are stored
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countEn <= 1'b0;
      alarmEn <= 1'b0;
    end else if (wrEn && addr == CTRL_A) begin
      countEn <= wrCntBit;
      alarmEn <= wrAlmBit;
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (addr == CTRL_A) begin
      rdData[CNT_EN_BIT] = countEn;
      rdData[ALM_EN_BIT] = alarmEn;
    end else if (addr == CTRL2_A) begin
      rdData[PEND_BIT] = pending;
    end else begin
      for (int b = 0; b < BYTES; b++) begin
        if (addr == RD_A + ADDR_W'(b)) rdData = liveCount[b*DATA_W +: DATA_W];
        if (addr == AL_A + ADDR_W'(b)) rdData = alarmVal[b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/secRtcDatapath.sv
module secRtcDatapath
  import secRtcPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BYTES  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic                     countEn,
  input  logic                     alarmEn,
  input  logic [DATA_W-1:0]        wrData,
  input  rtcStrobes_t              strb,
  output logic [BYTES*DATA_W-1:0]  liveCount,
  output logic [BYTES*DATA_W-1:0]  alarmVal,
  output logic                     pending
);
  localparam int CW = BYTES * DATA_W;

  logic [BYTES-1:1][DATA_W-1:0] stage;
  logic [BYTES-1:0][DATA_W-1:0] alarmReg;
  logic                         fire;

  // staging for upper time bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage <= '0;
    end else if (strb.stageWr) begin
      for (int b = 1; b < BYTES; b++)
        if (strb.byteIdx == IDX_W'(b)) stage[b] <= wrData;
    end
  end

  // alarm value lanes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmReg <= '0;
    end else if (strb.almWr) begin
      for (int b = 0; b < BYTES; b++)
        if (strb.byteIdx == IDX_W'(b)) alarmReg[b] <= wrData;
    end
  end
  assign alarmVal = alarmReg;

  // live counter: atomic load beats tick
  always_ff @(posedge clk) begin
    if (!rstN)                 liveCount <= '0;
    else if (strb.loadLive)    liveCount <= {stage, wrData};
    else if (tick && countEn)  liveCount <= liveCount + CW'(1);
  end

  assign fire = tick && countEn && alarmEn && (liveCount == alarmVal);

  // sticky pending, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)             pending <= 1'b0;
    else if (fire)         pending <= 1'b1;
    else if (strb.clrPend) pending <= 1'b0;
  end
endmodule

// File: rtl/secAlarmRtc.sv
module secAlarmRtc
  import secRtcPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq
);
  localparam int CW = BYTES * DATA_W;

  rtcStrobes_t   strb;
  logic          countEn;
  logic          alarmEn;
  logic          pending;
  logic [CW-1:0] liveCount;
  logic [CW-1:0] alarmVal;

  secRtcCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrEn      (wrEn),
    .wrCntBit  (wrData[CNT_EN_BIT]),
    .wrAlmBit  (wrData[ALM_EN_BIT]),
    .wrPendBit (wrData[PEND_BIT]),
    .liveCount (liveCount),
    .alarmVal  (alarmVal),
    .pending   (pending),
    .strb      (strb),
    .countEn   (countEn),
    .alarmEn   (alarmEn),
    .rdData    (rdData)
  );

  secRtcDatapath #(.DATA_W(DATA_W), .BYTES(BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .countEn   (countEn),
    .alarmEn   (alarmEn),
    .wrData    (wrData),
    .strb      (strb),
    .liveCount (liveCount),
    .alarmVal  (alarmVal),
    .pending   (pending)
  );

  assign alarmIrq = pending;
endmodule

// File: rtl/secRtcChecker.sv
module secRtcChecker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BYTES  = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    tick,
  input logic [ADDR_W-1:0]       addr,
  input logic [DATA_W-1:0]       wrData,
  input logic                    wrEn,
  input logic [DATA_W-1:0]       rdData,
  input logic                    alarmIrq,
  input logic                    countEn,
  input logic [BYTES*DATA_W-1:0] liveCount
);
  localparam int CW = BYTES * DATA_W;
  localparam logic [ADDR_W-1:0] WR_A  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] CL_A  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RD_A  = ADDR_W'(2 + BYTES);

  logic loadNow;
  assign loadNow = wrEn && addr == WR_A;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    countEn && tick && !loadNow |=> liveCount == CW'($past(liveCount) + CW'(1))); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !countEn && !loadNow |=> $stable(liveCount)); // R3
  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    loadNow |=> liveCount[DATA_W-1:0] == $past(wrData)); // R5
  AST_READ_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    addr == RD_A |-> rdData == liveCount[DATA_W-1:0]); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq && !(wrEn && addr == CL_A && wrData[0]) |=> alarmIrq); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq && wrEn && addr == CL_A && wrData[0] && !tick |=> !alarmIrq); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> $past(tick) && $past(countEn)); // R10
endmodule

bind secAlarmRtc secRtcChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdData(rdData), .alarmIrq(alarmIrq), .countEn(countEn), .liveCount(liveCount)
);

// File: tb/test_secAlarmRtc.sv
`timescale 1ns/1ps
module test_secAlarmRtc;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;
  logic       alarmIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  secAlarmRtc i_secAlarmRtc (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdData(rdData), .alarmIrq(alarmIrq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] nextCount(logic [31:0] v, int n);
    return v + 32'(n);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic readTime(output logic [31:0] t);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(4'(6 + i), b); t[i*8 +: 8] = b; end
  endtask

  task automatic readAlarm(output logic [31:0] t);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(4'(10 + i), b); t[i*8 +: 8] = b; end
  endtask

  task automatic loadTime(logic [31:0] v);
    wr(4'd3, v[15:8]); wr(4'd4, v[23:16]); wr(4'd5, v[31:24]); wr(4'd2, v[7:0]);
  endtask

  task automatic setAlarm(logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(4'(10 + i), v[i*8 +: 8]);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] t, exp;
    logic [7:0]  b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readTime(t);  chk("R1 time", t, 0);
    readAlarm(t); chk("R1 alarm", t, 0);
    rd(4'd0, b);  chk("R1 ctrl", 32'(b), 0);
    rd(4'd1, b);  chk("R1 pending", 32'(b), 0);
    chk("R1 irq", 32'(alarmIrq), 0);

    // R2 only bits 7 and 1 stored
    wr(4'd0, 8'hFF); rd(4'd0, b); chk("R2 ctrl readback", 32'(b), 32'h82);
    wr(4'd0, 8'h00); rd(4'd0, b); chk("R2 ctrl cleared", 32'(b), 0);

    // R4 staging does not touch counter
    wr(4'd3, 8'hAA); wr(4'd4, 8'hBB); wr(4'd5, 8'hCC);
    readTime(t); chk("R4 staged only", t, 0);
    // R5 low byte commits
    wr(4'd2, 8'h11); readTime(t); chk("R5 commit", t, 32'hCCBBAA11);
    // R11 write window and unmapped read zero
    rd(4'd3, b);  chk("R11 write window", 32'(b), 0);
    rd(4'd2, b);  chk("R11 low write byte", 32'(b), 0);
    rd(4'd14, b); chk("R11 unmapped 14", 32'(b), 0);
    rd(4'd15, b); chk("R11 unmapped 15", 32'(b), 0);

    // R3 hold when disabled, count when enabled, wrap
    ticks(5); readTime(t); chk("R3 hold", t, 32'hCCBBAA11);
    wr(4'd0, 8'h80); ticks(5); readTime(t); chk("R3 count", t, nextCount(32'hCCBBAA11, 5));
    loadTime(32'hFFFFFFFE); ticks(2); readTime(t); chk("R3 wrap", t, 0);

    // R5 load wins over tick in same cycle (staging holds FF FF FF)
    @(negedge clk); addr = 4'd2; wrData = 8'h40; wrEn = 1'b1; tick = 1'b1;
    @(negedge clk); wrEn = 1'b0; tick = 1'b0;
    readTime(t); chk("R5 load beats tick", t, 32'hFFFFFF40);
    wr(4'd0, 8'h00);

    // R6 writes to read window ignored
    wr(4'd6, 8'h55); wr(4'd9, 8'h00); readTime(t); chk("R6 read window write", t, 32'hFFFFFF40);

    // R7 random alarm values, R5 random loads, R3 random tick runs
    for (int k = 0; k < 8; k++) begin
      logic [31:0] v;
      int n;
      v = $urandom();
      setAlarm(v); readAlarm(t); chk("R7 alarm readback", t, v);
      v = $urandom();
      loadTime(v); readTime(t); chk("R5 random load", t, v);
      n = int'($urandom_range(1, 6));
      wr(4'd0, 8'h80); ticks(n); wr(4'd0, 8'h00);
      readTime(t); chk("R3 random run", t, nextCount(v, n));
    end

    // R8 alarm fires on the matching tick and sticks
    setAlarm(32'h00000100); loadTime(32'h000000FE); wr(4'd0, 8'h82);
    ticks(2); chk("R8 before match", 32'(alarmIrq), 0);
    ticks(1); chk("R8 fired", 32'(alarmIrq), 1);
    rd(4'd1, b); chk("R9 pending reads 1", 32'(b), 1);
    ticks(3); chk("R8 sticky", 32'(alarmIrq), 1);
    // R9 write 0 no effect, write 1 clears
    wr(4'd1, 8'h00); chk("R9 write zero", 32'(alarmIrq), 1);
    wr(4'd1, 8'h01); chk("R9 clear", 32'(alarmIrq), 0);
    rd(4'd1, b); chk("R9 pending reads 0", 32'(b), 0);

    // R10 alarm disabled
    wr(4'd0, 8'h80); loadTime(32'h000000FE); ticks(3);
    chk("R10 alarm disabled", 32'(alarmIrq), 0);
    // R10 counting disabled
    wr(4'd0, 8'h02); loadTime(32'h00000100); ticks(2);
    chk("R10 counting disabled", 32'(alarmIrq), 0);
    readTime(t); chk("R10 count held", t, 32'h00000100);

    // R9 set wins over clear in the same cycle
    wr(4'd0, 8'h82);
    @(negedge clk); addr = 4'd1; wrData = 8'h01; wrEn = 1'b1; tick = 1'b1;
    @(negedge clk); wrEn = 1'b0; tick = 1'b0;
    chk("R9 set beats clear", 32'(alarmIrq), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule